// File: doc/BRIEF.md
# Countdown Watchdog with Selectable Expiry Action

This block is a watchdog timer that software reaches through a small 32-bit register bus with a byte address, a write strobe, write data, a read strobe and read data. It has two word registers. The timer register holds a count of clock ticks. The control register selects what happens on expiry: nothing, a general-purpose interrupt, a non-maskable interrupt, or a full-chip reset request. Once a non-zero action is selected, the count falls by one every clock. Software keeps the watchdog alive by rewriting the timer register before the count reaches zero. A value written to the timer reaches the live count only after a fixed load delay.

A four-state machine sequences the expiry. The states are IDLE, COUNT, FIRE and HOLD.
- IDLE to COUNT: a non-zero action while the count is non-zero.
- IDLE to FIRE: a non-zero action while the count is already zero.
- COUNT to FIRE: the count is zero.
- FIRE to HOLD: always, after one cycle.
- HOLD to COUNT: a reload takes effect.
- Any state to IDLE: the action becomes zero.
- Any state to COUNT: a reload takes effect while the action is non-zero.

The interrupt outputs are levels held through FIRE and HOLD. The reset request is asserted only in FIRE. A flag records that the watchdog issued a reset request. It is cleared only by a separate power-on reset, so software can still read it after the chip reset that the request triggered.

Top module: `expiry_watchdog`

## Requirements
- R1: After `rst_n` is released, the action reads 0, the timer reads 0xFFFFFFFF, and all three event outputs are low.
- R2: Control is at byte offset 0x00 and timer at 0x04. Control bits [1:0] hold the action: 0 is off, 1 is interrupt, 2 is NMI, 3 is chip reset. Bit 31 is the read-only watchdog-reset flag. All other control bits read 0. The timer register reads the live count. Read data is 0 while the read strobe is low.
- R3: A timer write takes effect on the 4th clock edge after the edge that captured it. Reads before that edge return the old count. A newer write restarts the delay.
- R4: While the action is non-zero, the count drops by one per clock and stops at 0. While the action is 0, the count holds.
- R5: The expiry output rises on the edge after the one that brought the count to zero. If the count is already zero when the action becomes non-zero, it rises on the edge after the arming edge.
- R6: With action 1, `irq_o` stays high from expiry until a reload takes effect or the action is set to 0.
- R7: With action 2, `nmi_o` behaves the same way as `irq_o` does under R6.
- R8: With action 3, `chip_rst_req_o` is high for exactly one cycle per expiry.
- R9: At most one of the three event outputs is high at any time.
- R10: Writing action 0 stops the count and drives all event outputs low from the edge that captured the write.
- R11: The flag is set by a reset request. It is cleared only by `por_n` and is kept through `rst_n`.
- R12: Timer rewrites that take effect before the count reaches zero prevent any expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| por_n | input | 1 | Asynchronous active-low power-on reset, clears the flag |
| bus_addr | input | 3 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational |
| irq_o | output | 1 | General-purpose interrupt level |
| nmi_o | output | 1 | Non-maskable interrupt level |
| chip_rst_req_o | output | 1 | One-cycle full-chip reset request |

## Verification
The assertions check the following on every cycle:
- the count never changes except by a single decrement or a completed load, and never wraps below zero;
- an output rises only after a zero count;
- the interrupt levels hold until a reload or a disable, and the reset request is one cycle wide;
- the outputs are mutually exclusive;
- the flag follows a reset request;
- the padding bits of the control word read as zero.

Only the bench's scenarios can show the exact latencies. These are the 4-cycle load delay, and the expiry edge for each action across a sweep of timeout values. The scenarios also show that keepalive rewrites prevent expiry, that the count freezes at its computed value after a mid-count disable, and that the flag is kept through `rst_n` and cleared by `por_n`.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ACT_OFF = 2'd0,
        ACT_IRQ = 2'd1,
        ACT_NMI = 2'd2,
        ACT_RST = 2'd3
    } wdt_act_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_COUNT = 2'd1,
        S_FIRE  = 2'd2,
        S_HOLD  = 2'd3
    } wdt_state_e;

    localparam int CTRL_OFFSET  = 0;
    localparam int TIMER_OFFSET = 4;
    localparam int FLAG_BIT     = 31;

endpackage

// File: rtl/wdt_loader.sv
module wdt_loader #(
    parameter int CNT_W    = 32,
    parameter int LOAD_LAT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [CNT_W-1:0] wr_val,
    output logic             load_done,
    output logic [CNT_W-1:0] load_val
);
    localparam int LAT_W = $clog2(LOAD_LAT + 1);

    logic [LAT_W-1:0] wait_q;
    logic [CNT_W-1:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q <= '0;
            pend_q <= '0;
        end else if (wr_stb) begin
            wait_q <= LAT_W'(LOAD_LAT);
            pend_q <= wr_val;
        end else if (wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
        end
    end

    assign load_done = (wait_q == LAT_W'(1));
    assign load_val  = pend_q;

    // R3: a fresh write never completes on the very next edge when the delay exceeds one
    p_no_early_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (LOAD_LAT > 1) && $past(wr_stb) |-> !load_done);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load_done,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             zero
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '1;
        else if (load_done)
            count <= load_val;
        else if (run && count != '0)
            count <= count - 1'b1;
    end

    assign zero = (count == '0);

    // R4: without a load, the count is held or falls by exactly one
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_done) |-> (count == $past(count) || count == $past(count) - 1'b1));

    // R4: no wrap below zero
    p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(count) == '0 && !$past(load_done) |-> count == '0);

    // R4: frozen while the action is off
    p_hold_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) && !$past(load_done) |-> $stable(count));

endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  wdt_act_e action,
    input  logic     zero,
    input  logic     load_done,
    output logic     irq,
    output logic     nmi,
    output logic     rst_req
);
    wdt_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (action == ACT_OFF) begin
            state_d = S_IDLE;
        end else if (load_done) begin
            state_d = S_COUNT;
        end else begin
            unique case (state_q)
                S_IDLE:  state_d = zero ? S_FIRE : S_COUNT;
                S_COUNT: state_d = zero ? S_FIRE : S_COUNT;
                S_FIRE:  state_d = S_HOLD;
                S_HOLD:  state_d = S_HOLD;
                default: state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    logic expired;

    always_comb begin
        expired = (state_q == S_FIRE) || (state_q == S_HOLD);
        irq     = expired && (action == ACT_IRQ);
        nmi     = expired && (action == ACT_NMI);
        rst_req = (state_q == S_FIRE) && (action == ACT_RST);
    end

    // R8: the reset request is a single-cycle pulse
    p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R9: the outputs are mutually exclusive
    p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq, nmi, rst_req}));

    // R5: an output rises under a steady action only after a zero count
    p_rise_after_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq || nmi || rst_req) && !$past(irq || nmi || rst_req) && $stable(action)
        |-> $past(zero));

    // R6: the interrupt level holds until a reload lands or the action changes
    p_irq_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(irq) && !$past(load_done) && action == ACT_IRQ |-> irq);

    // R7: the NMI level holds under the same conditions
    p_nmi_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(nmi) && !$past(load_done) && action == ACT_NMI |-> nmi);

    // R10: an action held at off keeps every output low
    p_quiet_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(action) == ACT_OFF && action == ACT_OFF |-> !(irq || nmi || rst_req));

endmodule

// File: rtl/expiry_watchdog.sv
module expiry_watchdog
    import wdt_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int CNT_W    = 32,
    parameter int LOAD_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              irq_o,
    output logic              nmi_o,
    output logic              chip_rst_req_o
);
    localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_OFFSET);
    localparam logic [ADDR_W-1:0] TIMER_A = ADDR_W'(TIMER_OFFSET);

    logic ctrl_hit, timer_hit;
    assign ctrl_hit  = (bus_addr == CTRL_A);
    assign timer_hit = (bus_addr == TIMER_A);

    wdt_act_e action_q;
    logic     wdt_flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            action_q <= ACT_OFF;
        else if (bus_wr && ctrl_hit)
            action_q <= wdt_act_e'(bus_wdata[1:0]);
    end

    logic             load_done;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] count;
    logic             zero;

    wdt_loader #(.CNT_W(CNT_W), .LOAD_LAT(LOAD_LAT)) u_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (bus_wr && timer_hit),
        .wr_val    (bus_wdata[CNT_W-1:0]),
        .load_done (load_done),
        .load_val  (load_val)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (action_q != ACT_OFF),
        .load_done (load_done),
        .load_val  (load_val),
        .count     (count),
        .zero      (zero)
    );

    wdt_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .action    (action_q),
        .zero      (zero),
        .load_done (load_done),
        .irq       (irq_o),
        .nmi       (nmi_o),
        .rst_req   (chip_rst_req_o)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            wdt_flag_q <= 1'b0;
        else if (chip_rst_req_o)
            wdt_flag_q <= 1'b1;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (ctrl_hit) begin
                bus_rdata[1:0]      = action_q;
                bus_rdata[FLAG_BIT] = wdt_flag_q;
            end else if (timer_hit) begin
                bus_rdata = 32'(count);
            end
        end
    end

    // R11: a reset request leaves the flag set
    p_flag_set_r11: assert property (@(posedge clk) disable iff (!por_n)
        chip_rst_req_o |=> wdt_flag_q);

    // R2: unused control bits read as zero
    p_ctrl_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && ctrl_hit |-> bus_rdata[30:2] == '0);

endmodule

// File: tb/expiry_watchdog_test.sv
`timescale 1ns/1ps
module expiry_watchdog_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_o, nmi_o, chip_rst_req_o;

    int checks = 0;
    int fails  = 0;
    logic exp_flag = 1'b0;

    always #2.5 clk = ~clk;

    expiry_watchdog uut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .nmi_o(nmi_o), .chip_rst_req_o(chip_rst_req_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #0.5;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic blk_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [31:0] outs();
        return {29'd0, chip_rst_req_o, nmi_o, irq_o};
    endfunction

    initial begin
        #1_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: got hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int vals[4] = '{0, 1, 2, 5};
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd4, d); check("R1 timer", d, 32'hFFFF_FFFF);
        rd(3'd0, d); check("R1 ctrl", d, 32'h0);
        check("R1 outputs", outs(), 32'h0);
        bus_addr = 3'd4; #0.5; check("R2 rdata idle", bus_rdata, 32'h0);

        // R3 load latency
        wr(3'd4, 32'd7);
        repeat (3) @(negedge clk);
        rd(3'd4, d); check("R3 old value before load", d, 32'hFFFF_FFFF);
        @(negedge clk);
        rd(3'd4, d); check("R3 new value after load", d, 32'd7);

        // R5..R9 sweep over action and timeout
        for (int a = 1; a <= 3; a++) begin
            foreach (vals[i]) begin
                blk_reset();
                wr(3'd4, vals[i]);
                repeat (4) @(negedge clk);
                wr(3'd0, a);
                rd(3'd0, d); check("R2 ctrl readback", d, {exp_flag, 29'd0, 2'(a)});
                repeat (vals[i]) @(negedge clk);
                check("R5 quiet before expiry", outs(), 32'h0);
                @(negedge clk);
                check("R5 R9 expiry output", outs(), 32'd1 << (a - 1));
                if (a == 3) exp_flag = 1'b1;
                @(negedge clk);
                if (a == 3) begin
                    check("R8 pulse width", outs(), 32'h0);
                    rd(3'd0, d); check("R11 flag set", d[31], 1'b1);
                end else begin
                    check(a == 1 ? "R6 irq level" : "R7 nmi level", outs(), 32'd1 << (a - 1));
                end
                wr(3'd0, 32'd0);
                check("R10 disable clears outputs", outs(), 32'h0);
            end
        end

        // R11 flag survives rst_n, cleared by por_n
        blk_reset();
        rd(3'd0, d); check("R11 flag kept through rst_n", d, 32'h8000_0000);
        por_n = 1'b0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        rd(3'd0, d); check("R11 flag cleared by por_n", d, 32'h0);

        // R10 R4 disable mid-count
        wr(3'd4, 32'd20);
        repeat (4) @(negedge clk);
        wr(3'd0, 32'd1);
        repeat (5) @(negedge clk);
        wr(3'd0, 32'd0);
        rd(3'd4, d); check("R4 count at disable", d, 32'd14);
        repeat (30) @(negedge clk);
        rd(3'd4, d); check("R10 count frozen", d, 32'd14);
        check("R10 no expiry when off", outs(), 32'h0);

        // R12 keepalive then R7 expiry and reload
        blk_reset();
        wr(3'd4, 32'd10);
        repeat (4) @(negedge clk);
        wr(3'd0, 32'd2);
        for (int k = 0; k < 8; k++) begin
            repeat (3) @(negedge clk);
            wr(3'd4, 32'd10);
            check("R12 no expiry during keepalive", outs(), 32'h0);
        end
        repeat (14) @(negedge clk);
        check("R12 quiet until reload runs out", outs(), 32'h0);
        @(negedge clk);
        check("R7 nmi after final reload", outs(), 32'd2);
        wr(3'd4, 32'd50);
        repeat (3) @(negedge clk);
        check("R7 nmi held while load pending", outs(), 32'd2);
        rd(3'd4, d); check("R3 old zero while pending", d, 32'd0);
        @(negedge clk);
        check("R7 nmi drops on reload", outs(), 32'h0);
        rd(3'd4, d); check("R3 reload value", d, 32'd50);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule